// File: doc/BRIEF.md
# Lockable Flash Timing Tick Divider

This block holds one 8-bit control register and a programmable prescaler. Together they turn the bus clock into a short timing tick of about 1 MHz. A nonvolatile-memory controller uses that tick to time its program and erase pulses. Software programs a 6-bit divide value. It may then freeze that value with a lock bit that only a reset clears. A read-only flag shows whether the register has been written since reset.

Writes are refused while a memory command is in progress. The one exception is the reset sequence, during which writes are accepted even though a command appears busy. The first accepted write starts the prescaler and raises the valid output. The command logic must not start any timed operation before valid is high.

Top module: `nvm_tick_gen`

## Requirements
- R1: After reset, every register bit reads 0, and tick_o and div_valid_o are low.
- R2: The read value is {written flag in bit 7, lock in bit 6, divide field in bits 5:0}.
- R3: The written flag becomes 1 on the first accepted write and stays 1 until reset. Bit 7 of the write data has no effect on it.
- R4: The lock bit can only go from 0 to 1 by writing a 1 to bit 6. Writing 0 to bit 6 never clears it. Only reset clears it.
- R5: While the lock bit is set, writes leave the divide field unchanged.
- R6: A write is ignored entirely (all fields, including the written flag) when cmd_busy_i is high and rst_seq_i is low.
- R7: A write is accepted when rst_seq_i is high, even if cmd_busy_i is high.
- R8: A write that sets bit 6 and carries a new divide value while unlocked stores the new value and locks it in the same cycle.
- R9: Once the written flag is set, tick_o is high for one cycle every N+1 clocks, where N is the divide field. With N = 0 it is high in every cycle.
- R10: A new divide value does not shorten or stretch the tick interval already in progress. It applies from the next tick onward.
- R11: div_valid_o equals the written flag. No tick occurs while the flag is 0. The first tick appears in the second cycle after the clock edge that accepts the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| cmd_busy_i | input | 1 | A memory command is executing |
| rst_seq_i | input | 1 | Controller reset sequence in progress |
| rd_data_o | output | 8 | Register read value |
| tick_o | output | 1 | One-cycle timing tick |
| div_valid_o | output | 1 | Divider has been programmed |

## Verification
Two things can happen in the same clock cycle: a write that sets the lock and also carries a new divide value, and a divide change that arrives while the prescaler is already counting out an interval. The bench provokes the first with one write that carries both the lock bit and a fresh field. It then sweeps every possible byte against the locked register and expects the readback to keep the value from that first write. The bench provokes the second by writing a shorter divide value right after an observed tick. It expects the next tick after the old interval and the following one after the new interval, both computed from the two divide values.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;
  parameter int unsigned DIV_W = 6;
  localparam int unsigned REG_W = DIV_W + 2;
  localparam int unsigned LOCK_BIT = DIV_W;
  localparam int unsigned DONE_BIT = DIV_W + 1;

  typedef logic [DIV_W-1:0] div_t;

  typedef struct packed {
    logic done;
    logic lock;
    div_t div;
  } cfg_t;
endpackage

// File: rtl/nvm_tick_cfg_reg.sv
module nvm_tick_cfg_reg
  import nvm_tick_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             cmd_busy_i,
  input  logic             rst_seq_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;
  logic wr_ok;

  // reset sequence overrides busy blocking
  assign wr_ok = wr_en_i & (~cmd_busy_i | rst_seq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      cfg_q.done <= 1'b1;
      cfg_q.lock <= cfg_q.lock | wr_data_i[LOCK_BIT];
      if (!cfg_q.lock) cfg_q.div <= wr_data_i[DIV_W-1:0];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/nvm_tick_prescaler.sv
module nvm_tick_prescaler
  import nvm_tick_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  div_t div_i,
  output logic tick_o
);
  div_t cnt_q;
  logic tick_q;
  logic wrap;

  assign wrap = (cnt_q == '0);

  // divide value sampled only at wrap: the running interval is never altered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      cnt_q  <= wrap ? div_i : cnt_q - 1'b1;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen
  import nvm_tick_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       cmd_busy_i,
  input  logic       rst_seq_i,
  output logic [7:0] rd_data_o,
  output logic       tick_o,
  output logic       div_valid_o
);
  cfg_t cfg;

  nvm_tick_cfg_reg i_cfg_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .cmd_busy_i (cmd_busy_i),
    .rst_seq_i  (rst_seq_i),
    .cfg_o      (cfg)
  );

  nvm_tick_prescaler i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (cfg.done),
    .div_i  (cfg.div),
    .tick_o (tick_o)
  );

  assign rd_data_o   = cfg;
  assign div_valid_o = cfg.done;
endmodule

// File: rtl/nvm_tick_gen_chk.sv
module nvm_tick_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       cmd_busy_i,
  input logic       rst_seq_i,
  input logic [7:0] rd_data_o,
  input logic       tick_o,
  input logic       div_valid_o
);
  // R3
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7] |=> rd_data_o[7]);

  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[6] |=> rd_data_o[6]);

  // R5
  locked_div_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[6] |=> $stable(rd_data_o[5:0]));

  // R6
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cmd_busy_i && !rst_seq_i) |=> $stable(rd_data_o));

  // R7
  seq_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rst_seq_i) |=> rd_data_o[7]);

  // R8
  unlocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (!cmd_busy_i || rst_seq_i) && !rd_data_o[6])
      |=> rd_data_o[6:0] == $past(wr_data_i[6:0]));

  // R11
  no_tick_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_valid_o |=> !tick_o);
endmodule

bind nvm_tick_gen nvm_tick_gen_chk i_chk (.*);

// File: tb/test_nvm_tick_gen.sv
module test_nvm_tick_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       cmd_busy_i = 1'b0;
  logic       rst_seq_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       tick_o;
  logic       div_valid_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  nvm_tick_gen i_nvm_tick_gen (.*);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; cmd_busy_i = 1'b0; rst_seq_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t1, t2, err;
    do_reset();
    // R1
    check("R1 rd", rd_data_o, 0);
    check("R1 valid", div_valid_o, 0);
    err = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (tick_o) err++;
    end
    check("R11 no tick before write", err, 0);

    // R6/R7: acceptance over busy x reset-sequence
    for (int c = 0; c < 4; c++) begin
      do_reset();
      cmd_busy_i = c[0]; rst_seq_i = c[1];
      wr(8'h25);
      cmd_busy_i = 1'b0; rst_seq_i = 1'b0;
      check(c == 1 ? "R6 busy write" : "R7 accepted write", rd_data_o,
            (c == 1) ? 0 : 8'hA5);
      check("R11 valid", div_valid_o, (c == 1) ? 0 : 1);
    end

    // R2/R3/R4 unlocked sweep of field values
    do_reset();
    err = 0;
    for (int v = 0; v < 64; v++) begin
      wr(8'(v));
      if (rd_data_o != (8'h80 | 8'(v))) err++;
    end
    check("R2 R3 R4 unlocked sweep mismatches", err, 0);
    wr(8'h80);
    check("R3 bit7 write no effect", rd_data_o, 8'h80);

    // R8 then R5/R4 exhaustive byte sweep against locked register
    do_reset();
    wr(8'h4A);
    check("R8 lock and field same write", rd_data_o, 8'hCA);
    err = 0;
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      if (rd_data_o != 8'hCA) err++;
    end
    check("R5 R4 locked sweep mismatches", err, 0);
    do_reset();
    check("R4 reset clears lock", rd_data_o, 0);

    // R9/R11 tick pattern for every divide value
    for (int d = 0; d < 64; d++) begin
      do_reset();
      wr(8'(d));
      err = 0;
      if (tick_o) err++;
      for (int i = 1; i <= 3 * (d + 1); i++) begin
        @(negedge clk_i);
        if (tick_o != (((i - 1) % (d + 1)) == 0)) err++;
      end
      check($sformatf("R9 R11 tick pattern div=%0d", d), err, 0);
    end

    // R10: change divide right after a tick
    do_reset();
    wr(8'h05);
    while (!tick_o) @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 8'h02;
    t1 = 0; t2 = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b0;
      if (tick_o && t1 == 0) t1 = i;
      else if (tick_o && t2 == 0) t2 = i;
    end
    check("R10 old interval kept", t1, 6);
    check("R10 new interval applied", t2, 9);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule